// File: doc/BRIEF.md
# Dual-Signature Output Commit Gate

This gate stands between two processors that run the same critical tasks on their own timing and the actuator outputs those tasks drive. Each processor posts its result for a task slot together with a signature word. The gate keeps each posted result in a buffer that belongs to that processor and that slot. When the other processor's copy for the same slot arrives, the gate checks both signatures against their fixed keys and compares the two data words. Only a pair that passes both tests is released to the output.

A free-running timer repeats with a programmable period. Inside each period, a programmable window is the only span in which results are accepted and released. A write that arrives while the window is shut is dropped and counted. When the window closes, any slot still holding an unmatched or undecided copy is reported as missing, and every buffer is emptied for the next period.

Non-critical traffic does not pass through this block. Only replicated critical results are presented to its write ports.

Top module: `dual_sig_commit_gate`

## Requirements
- R1: The timer runs from 0 to `cfg_period`-1 and wraps to 0. It starts at 0 when reset is released. `win_open` is 1 exactly when `cfg_win_start` <= timer < `cfg_win_start` + `cfg_win_len`.
- R2: A write taken while `win_open` is 1 is stored in the writing processor's buffer for `*_slot` (slot index = binary value of the port). A write to a buffer that is already full is ignored, so the first copy stays.
- R3: When a slot holds copies from both processors, both signatures equal their keys (A: `SIG_KEY_A`, default 8'hA5; B: `SIG_KEY_B`, default 8'h5A) and the data words are equal, `cmt_valid` pulses for one cycle with `dec_slot` and `cmt_data`. The pulse comes two rising edges after the edge that captured the second copy. The slot's buffers are then emptied.
- R4: When both signatures are good but the data words differ, `err_mismatch` pulses with `dec_slot` at the same point, and nothing is committed.
- R5: When either stored signature differs from its key, `err_sig` pulses with `dec_slot` and nothing is committed. This check is made before the data comparison, so `err_mismatch` does not pulse in this case.
- R6: A write presented while `win_open` is 0 is dropped. `guard_viol` pulses on the next cycle, and `guard_cnt` grows by the number of such writes in that cycle (0, 1 or 2).
- R7: On the first cycle after the window closes, `miss_mask` shows one bit per slot that still held any copy. All buffers are emptied at that edge, and nothing is committed for those slots.
- R8: At most one slot is decided per cycle. The lowest-numbered ready slot goes first and the rest follow on later cycles.
- R9: After reset, `cmt_valid`, `err_mismatch`, `err_sig`, `guard_viol`, `miss_mask` and `guard_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | CNT_W | Timer period in cycles |
| cfg_win_start | input | CNT_W | Timer value at which the window opens |
| cfg_win_len | input | CNT_W | Window length in cycles |
| a_wr | input | 1 | Processor A write strobe |
| a_slot | input | SLOT_W | Processor A task slot |
| a_data | input | DATA_W | Processor A result |
| a_sig | input | SIG_W | Processor A signature |
| b_wr | input | 1 | Processor B write strobe |
| b_slot | input | SLOT_W | Processor B task slot |
| b_data | input | DATA_W | Processor B result |
| b_sig | input | SIG_W | Processor B signature |
| win_open | output | 1 | Guardian window is open |
| cmt_valid | output | 1 | Commit pulse |
| cmt_data | output | DATA_W | Committed result |
| dec_slot | output | SLOT_W | Slot of the current decision |
| err_mismatch | output | 1 | Replica data disagreed |
| err_sig | output | 1 | A signature was absent or wrong |
| miss_mask | output | NUM_SLOTS | Slots left unresolved at window close |
| guard_viol | output | 1 | A write was dropped outside the window |
| guard_cnt | output | CNT_W | Running count of dropped writes |

## Verification
A decision is due two rising edges after the edge that captures the second copy: one edge fills the buffer and the next registers the verdict. The bench drives inputs on falling edges and reads the verdict on the second falling edge after the second copy is presented. Missing-copy flags are read one falling edge after `win_open` is first seen low. Guardian flags are read on the falling edge that follows the offending write. Window timing is checked against a cycle count the bench keeps from the moment it releases reset, at the cycles just before and at each edge of the window.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    DEC_NONE     = 2'd0,
    DEC_COMMIT   = 2'd1,
    DEC_MISMATCH = 2'd2,
    DEC_BADSIG   = 2'd3
  } dec_kind_t;
endpackage

// File: rtl/dsc_window.sv
module dsc_window #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_win_start,
  input  logic [CNT_W-1:0] cfg_win_len,
  output logic             win_open,
  output logic             win_close
);
  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic             open_q;
  logic [CNT_W:0]   win_end;

  assign win_end  = {1'b0, cfg_win_start} + {1'b0, cfg_win_len};
  assign win_open = (tcnt_q >= cfg_win_start) && ({1'b0, tcnt_q} < win_end);
  assign win_close = open_q && !win_open;

  always_comb begin
    if (tcnt_q >= cfg_period - CNT_W'(1)) tcnt_d = '0;
    else                                   tcnt_d = tcnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      open_q <= 1'b0;
    end else begin
      tcnt_q <= tcnt_d;
      open_q <= win_open;
    end
  end

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt_q == cfg_period - CNT_W'(1)) |=> (tcnt_q == '0));
endmodule

// File: rtl/dsc_replica_buf.sv
module dsc_replica_buf #(
  parameter int          DATA_W = 16,
  parameter int          SIG_W  = 8,
  parameter logic [SIG_W-1:0] SIG_KEY = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              clr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SIG_W-1:0]  wr_sig,
  output logic              vld,
  output logic [DATA_W-1:0] data_q,
  output logic              sig_ok
);
  logic load, vld_d;

  assign load  = wr && !vld;
  assign vld_d = (vld && !clr) || load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      sig_ok <= 1'b0;
    end else if (load) begin
      data_q <= wr_data;
      sig_ok <= (wr_sig == SIG_KEY);
    end
  end

  // R2
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !clr) |=> (vld && $stable(data_q) && $stable(sig_ok)));
endmodule

// File: rtl/dsc_pick.sv
module dsc_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = N'(1) << i;
        idx   = IW'(i);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/dual_sig_commit_gate.sv
module dual_sig_commit_gate
  import dsc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 16,
  parameter int SIG_W     = 8,
  parameter int CNT_W     = 12,
  parameter logic [SIG_W-1:0] SIG_KEY_A = 8'hA5,
  parameter logic [SIG_W-1:0] SIG_KEY_B = 8'h5A,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cfg_period,
  input  logic [CNT_W-1:0]     cfg_win_start,
  input  logic [CNT_W-1:0]     cfg_win_len,
  input  logic                 a_wr,
  input  logic [SLOT_W-1:0]    a_slot,
  input  logic [DATA_W-1:0]    a_data,
  input  logic [SIG_W-1:0]     a_sig,
  input  logic                 b_wr,
  input  logic [SLOT_W-1:0]    b_slot,
  input  logic [DATA_W-1:0]    b_data,
  input  logic [SIG_W-1:0]     b_sig,
  output logic                 win_open,
  output logic                 cmt_valid,
  output logic [DATA_W-1:0]    cmt_data,
  output logic [SLOT_W-1:0]    dec_slot,
  output logic                 err_mismatch,
  output logic                 err_sig,
  output logic [NUM_SLOTS-1:0] miss_mask,
  output logic                 guard_viol,
  output logic [CNT_W-1:0]     guard_cnt
);
  logic                 win_close;
  logic                 a_in, b_in;
  logic [NUM_SLOTS-1:0] a_vld, b_vld, a_sok, b_sok, clr, ready, grant;
  logic [DATA_W-1:0]    a_q [NUM_SLOTS];
  logic [DATA_W-1:0]    b_q [NUM_SLOTS];
  logic [SLOT_W-1:0]    gidx;
  logic                 gany;
  dec_kind_t            kind;
  logic [1:0]           viol_n;
  logic [NUM_SLOTS-1:0] miss_d;

  dsc_window #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .cfg_period(cfg_period), .cfg_win_start(cfg_win_start), .cfg_win_len(cfg_win_len),
    .win_open(win_open), .win_close(win_close)
  );

  assign a_in = a_wr && win_open;
  assign b_in = b_wr && win_open;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    dsc_replica_buf #(.DATA_W(DATA_W), .SIG_W(SIG_W), .SIG_KEY(SIG_KEY_A)) u_a (
      .clk(clk), .rst_n(rst_n),
      .wr(a_in && (a_slot == SLOT_W'(s))), .clr(clr[s]),
      .wr_data(a_data), .wr_sig(a_sig),
      .vld(a_vld[s]), .data_q(a_q[s]), .sig_ok(a_sok[s])
    );
    dsc_replica_buf #(.DATA_W(DATA_W), .SIG_W(SIG_W), .SIG_KEY(SIG_KEY_B)) u_b (
      .clk(clk), .rst_n(rst_n),
      .wr(b_in && (b_slot == SLOT_W'(s))), .clr(clr[s]),
      .wr_data(b_data), .wr_sig(b_sig),
      .vld(b_vld[s]), .data_q(b_q[s]), .sig_ok(b_sok[s])
    );
    assign ready[s] = a_vld[s] && b_vld[s] && win_open;
    assign clr[s]   = grant[s] || win_close;
  end

  dsc_pick #(.N(NUM_SLOTS), .IW(SLOT_W)) u_pick (
    .req(ready), .grant(grant), .idx(gidx), .any(gany)
  );

  // Next-state: verdict for the granted slot, close flush, guardian tally.
  always_comb begin
    kind = DEC_NONE;
    if (gany) begin
      if (!(a_sok[gidx] && b_sok[gidx]))  kind = DEC_BADSIG;
      else if (a_q[gidx] == b_q[gidx])    kind = DEC_COMMIT;
      else                                kind = DEC_MISMATCH;
    end
    miss_d = win_close ? (a_vld | b_vld) : '0;
    viol_n = {1'b0, a_wr && !win_open} + {1'b0, b_wr && !win_open};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmt_valid    <= 1'b0;
      err_mismatch <= 1'b0;
      err_sig      <= 1'b0;
      miss_mask    <= '0;
      guard_viol   <= 1'b0;
    end else begin
      cmt_valid    <= (kind == DEC_COMMIT);
      err_mismatch <= (kind == DEC_MISMATCH);
      err_sig      <= (kind == DEC_BADSIG);
      miss_mask    <= miss_d;
      guard_viol   <= (viol_n != 2'd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dec_slot <= '0;
    else if (gany) dec_slot <= gidx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cmt_data <= '0;
    else if (kind == DEC_COMMIT) cmt_data <= a_q[gidx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 guard_cnt <= '0;
    else if (viol_n != 2'd0)    guard_cnt <= guard_cnt + CNT_W'(viol_n);
  end

  // R3
  cmt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> $past(win_open));
  // R4
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmt_valid, err_mismatch, err_sig}) <= 1);
  // R6
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    guard_viol |-> $past((a_wr || b_wr) && !win_open));
  // R7
  miss_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_mask != '0) |-> ($past(!win_open) && !cmt_valid));
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~ready) == '0));
endmodule

// File: tb/sim_dual_sig_commit_gate.sv
module sim_dual_sig_commit_gate;
  localparam int NS = 4, DW = 16, SW = 8, CW = 12, SLW = 2;
  localparam logic [CW-1:0] PERIOD = 12'd20, WSTART = 12'd5, WLEN = 12'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_wr = 1'b0, b_wr = 1'b0;
  logic [SLW-1:0] a_slot = '0, b_slot = '0;
  logic [DW-1:0]  a_data = '0, b_data = '0;
  logic [SW-1:0]  a_sig = '0, b_sig = '0;
  logic win_open, cmt_valid, err_mismatch, err_sig, guard_viol;
  logic [DW-1:0] cmt_data;
  logic [SLW-1:0] dec_slot;
  logic [NS-1:0] miss_mask;
  logic [CW-1:0] guard_cnt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_sig_commit_gate u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_period(PERIOD), .cfg_win_start(WSTART), .cfg_win_len(WLEN),
    .a_wr(a_wr), .a_slot(a_slot), .a_data(a_data), .a_sig(a_sig),
    .b_wr(b_wr), .b_slot(b_slot), .b_data(b_data), .b_sig(b_sig),
    .win_open(win_open), .cmt_valid(cmt_valid), .cmt_data(cmt_data),
    .dec_slot(dec_slot), .err_mismatch(err_mismatch), .err_sig(err_sig),
    .miss_mask(miss_mask), .guard_viol(guard_viol), .guard_cnt(guard_cnt)
  );

  // {slot[2], a_data[16], a_sig[8], b_data[16], b_sig[8], outcome[2]}
  // outcome: 0 commit, 1 mismatch, 2 bad signature
  localparam int VN = 7;
  localparam logic [51:0] VEC [VN] = '{
    {2'd0, 16'h1234, 8'hA5, 16'h1234, 8'h5A, 2'd0},
    {2'd1, 16'h0000, 8'hA5, 16'h0000, 8'h5A, 2'd0},
    {2'd2, 16'hFFFF, 8'hA5, 16'hFFFE, 8'h5A, 2'd1},
    {2'd3, 16'h8001, 8'hA5, 16'h8001, 8'h00, 2'd2},
    {2'd3, 16'h7777, 8'h5A, 16'h7777, 8'h5A, 2'd2},
    {2'd2, 16'hABCD, 8'hA5, 16'hABCD, 8'h5A, 2'd0},
    {2'd1, 16'h0F0F, 8'hA5, 16'hF0F0, 8'hA5, 2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_window;
    while (win_open !== 1'b0) @(negedge clk);
    while (win_open !== 1'b1) @(negedge clk);
  endtask

  task automatic wait_close;
    while (win_open !== 1'b0) @(negedge clk);
  endtask

  task automatic drv_a(input logic [SLW-1:0] s, input logic [DW-1:0] d, input logic [SW-1:0] g);
    a_wr = 1'b1; a_slot = s; a_data = d; a_sig = g;
  endtask

  task automatic drv_b(input logic [SLW-1:0] s, input logic [DW-1:0] d, input logic [SW-1:0] g);
    b_wr = 1'b1; b_slot = s; b_data = d; b_sig = g;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state (timer = 0 at this falling edge)
    chk("R9 cmt_valid", 32'(cmt_valid), 0);
    chk("R9 err flags", 32'({err_mismatch, err_sig, guard_viol}), 0);
    chk("R9 miss_mask", 32'(miss_mask), 0);
    chk("R9 guard_cnt", 32'(guard_cnt), 0);
    chk("R1 win_open t=0", 32'(win_open), 0);
    // R1 window edges
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk);
      if (i == 4)  chk("R1 win_open t=4", 32'(win_open), 0);
      if (i == 5)  chk("R1 win_open t=5", 32'(win_open), 1);
      if (i == 12) chk("R1 win_open t=12", 32'(win_open), 1);
      if (i == 13) chk("R1 win_open t=13", 32'(win_open), 0);
    end

    // R3 R4 R5 table of replica pairs
    for (int v = 0; v < VN; v++) begin
      logic [51:0] e;
      e = VEC[v];
      wait_window;
      drv_a(e[51:50], e[49:34], e[33:26]);
      @(negedge clk);
      a_wr = 1'b0;
      drv_b(e[51:50], e[25:10], e[9:2]);
      @(negedge clk);
      b_wr = 1'b0;
      chk("R3 no early verdict", 32'({cmt_valid, err_mismatch, err_sig}), 0);
      @(negedge clk);
      chk("R3 cmt_valid", 32'(cmt_valid), 32'(e[1:0] == 2'd0));
      chk("R4 err_mismatch", 32'(err_mismatch), 32'(e[1:0] == 2'd1));
      chk("R5 err_sig", 32'(err_sig), 32'(e[1:0] == 2'd2));
      chk("R3 dec_slot", 32'(dec_slot), 32'(e[51:50]));
      if (e[1:0] == 2'd0) chk("R3 cmt_data", 32'(cmt_data), 32'(e[49:34]));
    end

    // R2 second write to a full buffer is ignored
    wait_window;
    drv_a(2'd0, 16'h1111, 8'hA5);
    @(negedge clk);
    drv_a(2'd0, 16'h2222, 8'hA5);
    @(negedge clk);
    a_wr = 1'b0;
    drv_b(2'd0, 16'h1111, 8'h5A);
    @(negedge clk);
    b_wr = 1'b0;
    @(negedge clk);
    chk("R2 first copy kept commit", 32'(cmt_valid), 1);
    chk("R2 first copy kept data", 32'(cmt_data), 32'h1111);

    // R8 two slots ready on the same edge
    wait_window;
    drv_a(2'd1, 16'h0010, 8'hA5);
    drv_b(2'd2, 16'h0020, 8'h5A);
    @(negedge clk);
    drv_a(2'd2, 16'h0020, 8'hA5);
    drv_b(2'd1, 16'h0010, 8'h5A);
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
    @(negedge clk);
    chk("R8 first slot", 32'({cmt_valid, dec_slot}), 32'({1'b1, 2'd1}));
    chk("R8 first data", 32'(cmt_data), 32'h0010);
    @(negedge clk);
    chk("R8 second slot", 32'({cmt_valid, dec_slot}), 32'({1'b1, 2'd2}));
    chk("R8 second data", 32'(cmt_data), 32'h0020);

    // R7 single copy left at close
    wait_window;
    drv_a(2'd0, 16'hBEEF, 8'hA5);
    @(negedge clk);
    a_wr = 1'b0;
    wait_close;
    @(negedge clk);
    chk("R7 miss_mask", 32'(miss_mask), 32'h1);
    chk("R7 no commit", 32'(cmt_valid), 0);
    @(negedge clk);
    chk("R7 miss pulse ends", 32'(miss_mask), 0);

    // R6 writes while the window is shut
    drv_a(2'd2, 16'h5555, 8'hA5);
    drv_b(2'd3, 16'h6666, 8'h5A);
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
    chk("R6 guard_viol", 32'(guard_viol), 1);
    chk("R6 guard_cnt +2", 32'(guard_cnt), 2);
    drv_a(2'd1, 16'h5555, 8'hA5);
    @(negedge clk);
    a_wr = 1'b0;
    chk("R6 guard_cnt +1", 32'(guard_cnt), 3);
    // R6 dropped copy for slot 2 must not pair with B in the next window
    wait_window;
    drv_b(2'd2, 16'h5555, 8'h5A);
    @(negedge clk);
    b_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 dropped write not stored", 32'(cmt_valid), 0);
    wait_close;
    @(negedge clk);
    chk("R6 R7 lone copy flagged", 32'(miss_mask), 32'h4);
    chk("R6 in-window write not counted", 32'(guard_cnt), 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule